// File: doc/BRIEF.md
# Decoder Job Parameter Checker

This block sits in front of an iterative channel decoder and screens each job's settings when the host issues a start command. It captures the operating mode, frame length, subframe length, prolog window length and the minimum and maximum iteration counts together with the start strobe. In the following cycle it tests them against the limits that apply to the selected mode. Each failed rule sets its own sticky bit in an error register. An interrupt pulse is raised, and the job is not passed on to the decoder.

When every rule passes and no earlier error is still pending, the block issues a one-cycle launch pulse toward the decoder control. The host reads the error bits and clears them by writing ones. A second readable word holds a busy flag, which is derived from the decoder's state number as observed on an input.

Top module: `dec_cfg_checker`

## Requirements
- R1: With mode 0 (standalone), the frame rule fails when the frame length is below 40 or above 20730.
- R2: With mode 1 or mode 2 (shared processing), the frame rule fails when the frame length is below 256, above 20480, or not a whole multiple of 256.
- R3: With mode 3 (shared processing), the frame rule fails when the frame length is below 128 or above 20480. The multiple-of-256 rule does not apply in this mode.
- R4: The subframe rule fails when the subframe length is greater than 5114, in every mode.
- R5: The prolog rule fails when the prolog length is below 4 or above 48.
- R6: The iteration rule fails when the minimum iteration count is greater than the maximum. Equal counts pass.
- R7: Parameters are sampled at the clock edge where start_i is high. At the next edge, each failing rule sets its error bit and irq_o pulses high for one cycle. irq_o stays low for a start where all rules pass.
- R8: At that same edge, launch_o pulses for one cycle only if no rule fails and no error bit is still set. It never coincides with irq_o.
- R9: Error bits are sticky. Reading address 0 returns {iter, prolog, subframe, frame} in bits 3..0. A write to address 0 clears exactly the bits written as 1. A bit being set in the same cycle wins over a clear.
- R10: busy_o, and bit 0 read at address 1, is 1 when dec_state_i is 1 through 8 and 0 for state 0 and for all other values.
- R11: After reset, the error bits, irq_o and launch_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start strobe; parameters sampled with it |
| mode_i | input | 2 | Operating mode: 0 standalone, 1..3 shared processing |
| frame_len_i | input | 15 | Frame length |
| subframe_len_i | input | 13 | Subframe length |
| prolog_len_i | input | 6 | Prolog window length |
| min_iter_i | input | 5 | Minimum iteration count |
| max_iter_i | input | 5 | Maximum iteration count |
| dec_state_i | input | 4 | Decoder state number |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 errors, 1 status |
| reg_wdata_i | input | 4 | Write data; ones clear error bits |
| reg_rdata_o | output | 4 | Read data for reg_addr_i |
| irq_o | output | 1 | Error interrupt pulse |
| launch_o | output | 1 | Decoder launch pulse |
| busy_o | output | 1 | Decoder busy flag |

## Verification
On every cycle, the assertions check the following. An interrupt or launch pulse only follows a start two edges earlier. The two pulses never coincide. An interrupt always leaves at least one error bit set. Error bits only fall after a clear write. An idle state never reports busy. The exact boundary values of each length rule and their dependence on mode can only be shown by the bench scenarios. The same holds for blocking a clean job while an older error is still pending, and for the precedence of a new error over a clear in the same cycle. The bench covers these with directed edge values on both sides of every limit, together with seeded random jobs.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int ERR_W = 4;
  localparam int ERR_FRAME  = 0;
  localparam int ERR_SUB    = 1;
  localparam int ERR_PROLOG = 2;
  localparam int ERR_ITER   = 3;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'd0,
    MODE_SHR_A = 2'd1,
    MODE_SHR_B = 2'd2,
    MODE_SHR_C = 2'd3
  } op_mode_e;
endpackage

// File: rtl/dcc_cfg_capture.sv
module dcc_cfg_capture #(
  parameter int FRAME_W = 15,
  parameter int SUB_W   = 13,
  parameter int PRO_W   = 6,
  parameter int ITER_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [SUB_W-1:0]   sub_i,
  input  logic [PRO_W-1:0]   prolog_i,
  input  logic [ITER_W-1:0]  min_i,
  input  logic [ITER_W-1:0]  max_i,
  output logic               check_o,
  output logic [1:0]         mode_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic [PRO_W-1:0]   prolog_o,
  output logic [ITER_W-1:0]  min_o,
  output logic [ITER_W-1:0]  max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      check_o  <= 1'b0;
      mode_o   <= '0;
      frame_o  <= '0;
      sub_o    <= '0;
      prolog_o <= '0;
      min_o    <= '0;
      max_o    <= '0;
    end else begin
      check_o <= start_i;
      if (start_i) begin
        mode_o   <= mode_i;
        frame_o  <= frame_i;
        sub_o    <= sub_i;
        prolog_o <= prolog_i;
        min_o    <= min_i;
        max_o    <= max_i;
      end
    end
  end
endmodule

// File: rtl/dcc_rule_eval.sv
module dcc_rule_eval
  import dcc_pkg::*;
#(
  parameter int FRAME_W     = 15,
  parameter int SUB_W       = 13,
  parameter int PRO_W       = 6,
  parameter int ITER_W      = 5,
  parameter int SOLO_MIN    = 40,
  parameter int SOLO_MAX    = 20730,
  parameter int SHR_AB_MIN  = 256,
  parameter int SHR_C_MIN   = 128,
  parameter int SHR_MAX     = 20480,
  parameter int ALIGN_LOG2  = 8,
  parameter int SUB_MAX     = 5114,
  parameter int PRO_MIN     = 4,
  parameter int PRO_MAX     = 48
) (
  input  logic [1:0]         mode_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [SUB_W-1:0]   sub_i,
  input  logic [PRO_W-1:0]   prolog_i,
  input  logic [ITER_W-1:0]  min_i,
  input  logic [ITER_W-1:0]  max_i,
  output logic [ERR_W-1:0]   fail_o
);
  localparam int FW = FRAME_W + 1;
  localparam logic [FW-1:0] SOLO_LO = FW'(SOLO_MIN);
  localparam logic [FW-1:0] SOLO_HI = FW'(SOLO_MAX);
  localparam logic [FW-1:0] AB_LO   = FW'(SHR_AB_MIN);
  localparam logic [FW-1:0] C_LO    = FW'(SHR_C_MIN);
  localparam logic [FW-1:0] SHR_HI  = FW'(SHR_MAX);
  localparam logic [SUB_W:0] SUB_HI = (SUB_W+1)'(SUB_MAX);
  localparam logic [PRO_W:0] PRO_LO = (PRO_W+1)'(PRO_MIN);
  localparam logic [PRO_W:0] PRO_HI = (PRO_W+1)'(PRO_MAX);

  logic [FW-1:0]    frame_x;
  logic [SUB_W:0]   sub_x;
  logic [PRO_W:0]   pro_x;
  logic             misaligned;
  logic             frame_bad;

  assign frame_x    = {1'b0, frame_i};
  assign sub_x      = {1'b0, sub_i};
  assign pro_x      = {1'b0, prolog_i};
  assign misaligned = |frame_i[ALIGN_LOG2-1:0];

  always_comb begin
    unique case (op_mode_e'(mode_i))
      MODE_SOLO:             frame_bad = (frame_x < SOLO_LO) || (frame_x > SOLO_HI);
      MODE_SHR_A, MODE_SHR_B: frame_bad = (frame_x < AB_LO) || (frame_x > SHR_HI) || misaligned;
      default:               frame_bad = (frame_x < C_LO) || (frame_x > SHR_HI);
    endcase
  end

  always_comb begin
    fail_o             = '0;
    fail_o[ERR_FRAME]  = frame_bad;
    fail_o[ERR_SUB]    = sub_x > SUB_HI;
    fail_o[ERR_PROLOG] = (pro_x < PRO_LO) || (pro_x > PRO_HI);
    fail_o[ERR_ITER]   = min_i > max_i;
  end
endmodule

// File: rtl/dcc_err_reg.sv
module dcc_err_reg
  import dcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             check_i,
  input  logic [ERR_W-1:0] fail_i,
  input  logic             clr_we_i,
  input  logic [ERR_W-1:0] clr_mask_i,
  output logic [ERR_W-1:0] err_o,
  output logic             irq_o,
  output logic             launch_o
);
  logic [ERR_W-1:0] set_v;
  logic [ERR_W-1:0] clr_v;

  assign set_v = check_i ? fail_i : '0;
  assign clr_v = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= '0;
      irq_o    <= 1'b0;
      launch_o <= 1'b0;
    end else begin
      // a new failure wins over a same-cycle clear
      err_o    <= (err_o & ~clr_v) | set_v;
      irq_o    <= |set_v;
      // pending errors block the job even when this one is clean
      launch_o <= check_i && !(|fail_i) && !(|err_o);
    end
  end
endmodule

// File: rtl/dec_cfg_checker.sv
module dec_cfg_checker
  import dcc_pkg::*;
#(
  parameter int FRAME_W = 15,
  parameter int SUB_W   = 13,
  parameter int PRO_W   = 6,
  parameter int ITER_W  = 5,
  parameter int STATE_W = 4,
  parameter int BUSY_LO = 1,
  parameter int BUSY_HI = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [FRAME_W-1:0] frame_len_i,
  input  logic [SUB_W-1:0]   subframe_len_i,
  input  logic [PRO_W-1:0]   prolog_len_i,
  input  logic [ITER_W-1:0]  min_iter_i,
  input  logic [ITER_W-1:0]  max_iter_i,
  input  logic [STATE_W-1:0] dec_state_i,
  input  logic               reg_wr_i,
  input  logic               reg_addr_i,
  input  logic [ERR_W-1:0]   reg_wdata_i,
  output logic [ERR_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic               launch_o,
  output logic               busy_o
);
  localparam logic [STATE_W-1:0] ST_LO = STATE_W'(BUSY_LO);
  localparam logic [STATE_W-1:0] ST_HI = STATE_W'(BUSY_HI);

  logic               check_q;
  logic [1:0]         mode_q;
  logic [FRAME_W-1:0] frame_q;
  logic [SUB_W-1:0]   sub_q;
  logic [PRO_W-1:0]   prolog_q;
  logic [ITER_W-1:0]  min_q;
  logic [ITER_W-1:0]  max_q;
  logic [ERR_W-1:0]   fail;
  logic [ERR_W-1:0]   err_q;

  dcc_cfg_capture #(
    .FRAME_W(FRAME_W), .SUB_W(SUB_W), .PRO_W(PRO_W), .ITER_W(ITER_W)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .frame_i  (frame_len_i),
    .sub_i    (subframe_len_i),
    .prolog_i (prolog_len_i),
    .min_i    (min_iter_i),
    .max_i    (max_iter_i),
    .check_o  (check_q),
    .mode_o   (mode_q),
    .frame_o  (frame_q),
    .sub_o    (sub_q),
    .prolog_o (prolog_q),
    .min_o    (min_q),
    .max_o    (max_q)
  );

  dcc_rule_eval #(
    .FRAME_W(FRAME_W), .SUB_W(SUB_W), .PRO_W(PRO_W), .ITER_W(ITER_W)
  ) u_rules (
    .mode_i   (mode_q),
    .frame_i  (frame_q),
    .sub_i    (sub_q),
    .prolog_i (prolog_q),
    .min_i    (min_q),
    .max_i    (max_q),
    .fail_o   (fail)
  );

  dcc_err_reg u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .check_i    (check_q),
    .fail_i     (fail),
    .clr_we_i   (reg_wr_i && !reg_addr_i),
    .clr_mask_i (reg_wdata_i),
    .err_o      (err_q),
    .irq_o      (irq_o),
    .launch_o   (launch_o)
  );

  assign busy_o      = (dec_state_i >= ST_LO) && (dec_state_i <= ST_HI);
  assign reg_rdata_o = reg_addr_i ? {{(ERR_W-1){1'b0}}, busy_o} : err_q;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker
  import dcc_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               reg_wr_i,
  input logic               reg_addr_i,
  input logic [ERR_W-1:0]   err_q,
  input logic               irq_o,
  input logic               launch_o,
  input logic               busy_o,
  input logic [STATE_W-1:0] dec_state_i
);
  // R7: interrupt only two edges after a start
  a_r7_irq_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(start_i, 2));

  // R7: an interrupt leaves an error recorded
  a_r7_irq_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_q != '0));

  // R8: launch only two edges after a start
  a_r8_launch_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> $past(start_i, 2));

  // R8: launch and interrupt are exclusive
  a_r8_no_launch_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && irq_o));

  // R9: no bit falls without a clear write
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && !reg_addr_i) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R10: idle state never reports busy
  a_r10_idle_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_state_i == '0) |-> !busy_o);
endmodule

bind dec_cfg_checker dcc_checker #(.STATE_W(STATE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .err_q       (err_q),
  .irq_o       (irq_o),
  .launch_o    (launch_o),
  .busy_o      (busy_o),
  .dec_state_i (dec_state_i)
);

// File: tb/dec_cfg_checker_test.sv
module dec_cfg_checker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [14:0] frame_len_i = '0;
  logic [12:0] subframe_len_i = '0;
  logic [5:0]  prolog_len_i = '0;
  logic [4:0]  min_iter_i = '0;
  logic [4:0]  max_iter_i = '0;
  logic [3:0]  dec_state_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [3:0]  reg_wdata_i = '0;
  logic [3:0]  reg_rdata_o;
  logic        irq_o, launch_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model_err = '0;

  always #4 clk_i = ~clk_i;

  dec_cfg_checker uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_err(int m, int f, int s, int p, int mn, int mx);
    logic [3:0] e = '0;
    case (m)
      0:       e[0] = (f < 40) || (f > 20730);
      1, 2:    e[0] = (f < 256) || (f > 20480) || (f % 256 != 0);
      default: e[0] = (f < 128) || (f > 20480);
    endcase
    e[1] = s > 5114;
    e[2] = (p < 4) || (p > 48);
    e[3] = mn > mx;
    return e;
  endfunction

  task automatic clear(input logic [3:0] mask);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = mask;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
    model_err = model_err & ~mask;
    check("R9 clear", int'(reg_rdata_o), int'(model_err));
  endtask

  task automatic job(input string req, input int m, input int f, input int s,
                     input int p, input int mn, input int mx);
    logic [3:0] e;
    logic       lexp;
    e = exp_err(m, f, s, p, mn, mx);
    lexp = (e == 0) && (model_err == 0);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'(m); frame_len_i = 15'(f); subframe_len_i = 13'(s);
    prolog_len_i = 6'(p); min_iter_i = 5'(mn); max_iter_i = 5'(mx);
    @(negedge clk_i);
    start_i = 1'b0;
    @(posedge clk_i); #1;
    model_err = model_err | e;
    reg_addr_i = 1'b0;
    #1;
    check({req, " err"}, int'(reg_rdata_o), int'(model_err));
    check({"R7 irq ", req}, int'(irq_o), int'(e != 0));
    check({"R8 launch ", req}, int'(launch_o), int'(lexp));
    @(posedge clk_i); #1;
    check("R7 pulse width", int'(irq_o | launch_o), 0);
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R11 err", int'(reg_rdata_o), 0);
    check("R11 irq", int'(irq_o), 0);
    check("R11 launch", int'(launch_o), 0);
    rst_ni = 1'b1;

    // R1 standalone frame limits
    job("R1", 0, 40, 1000, 16, 1, 8);
    job("R1", 0, 20730, 1000, 16, 1, 8);
    job("R1", 0, 39, 1000, 16, 1, 8);     clear(4'hF);
    job("R1", 0, 20731, 1000, 16, 1, 8);  clear(4'hF);
    // R2 shared modes 1 and 2
    job("R2", 1, 256, 1000, 16, 1, 8);
    job("R2", 2, 20480, 1000, 16, 1, 8);
    job("R2", 1, 255, 1000, 16, 1, 8);    clear(4'hF);
    job("R2", 2, 257, 1000, 16, 1, 8);    clear(4'hF);
    job("R2", 1, 20736, 1000, 16, 1, 8);  clear(4'hF);
    job("R2", 2, 512, 1000, 16, 1, 8);
    // R3 mode 3
    job("R3", 3, 128, 1000, 16, 1, 8);
    job("R3", 3, 129, 1000, 16, 1, 8);
    job("R3", 3, 127, 1000, 16, 1, 8);    clear(4'hF);
    job("R3", 3, 20481, 1000, 16, 1, 8);  clear(4'hF);
    // R4 subframe
    job("R4", 0, 1000, 5114, 16, 1, 8);
    job("R4", 0, 1000, 5115, 16, 1, 8);   clear(4'hF);
    // R5 prolog
    job("R5", 0, 1000, 100, 4, 1, 8);
    job("R5", 0, 1000, 100, 48, 1, 8);
    job("R5", 0, 1000, 100, 3, 1, 8);     clear(4'hF);
    job("R5", 0, 1000, 100, 49, 1, 8);    clear(4'hF);
    // R6 iterations
    job("R6", 0, 1000, 100, 16, 8, 8);
    job("R6", 0, 1000, 100, 16, 9, 8);    clear(4'hF);

    // R8 pending error blocks a clean job; R9 partial clear keeps other bits
    job("R8 pend", 0, 39, 100, 3, 1, 8);
    job("R8 pend", 0, 1000, 100, 16, 1, 8);
    clear(4'b0001);
    check("R9 partial", int'(reg_rdata_o), 4'b0100);
    clear(4'b0100);
    job("R8 clean", 0, 1000, 100, 16, 1, 8);

    // R9 set wins over same-cycle clear
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'd0; frame_len_i = 15'd1000; subframe_len_i = 13'd100;
    prolog_len_i = 6'd16; min_iter_i = 5'd9; max_iter_i = 5'd2;
    @(negedge clk_i);
    start_i = 1'b0; reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 4'hF;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
    check("R9 set over clear", int'(reg_rdata_o), 4'b1000);
    model_err = 4'b1000;
    clear(4'hF);

    // R10 busy decode
    for (int st = 0; st < 16; st++) begin
      @(negedge clk_i);
      dec_state_i = 4'(st); reg_addr_i = 1'b1;
      #1;
      check("R10 busy", int'(busy_o), int'(st >= 1 && st <= 8));
      check("R10 status", int'(reg_rdata_o), int'(st >= 1 && st <= 8));
    end
    reg_addr_i = 1'b0; dec_state_i = '0;

    // random jobs
    for (int i = 0; i < 300; i++) begin
      int m, f, s, p, mn, mx;
      m  = int'($urandom % 4);
      f  = ($urandom % 3 == 0) ? int'(($urandom % 82) * 256) : int'($urandom % 21000);
      s  = int'($urandom % 5300);
      p  = int'($urandom % 56);
      mn = int'($urandom % 32);
      mx = int'($urandom % 32);
      job("R1-6 rand", m, f, s, p, mn, mx);
      if ($urandom % 2 == 0) clear(4'hF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule